// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a memory-mapped peripheral for a handheld platform. It keeps a small bank of 16-bit control registers and a 16-line general-purpose I/O port. Each port line has its own direction bit. A simple register bus reads and writes the bank. The bus carries an address inside a 4 KiB window, a write enable, write data and combinational read data.

External agents can force single bits of the GPIO level register. A strobe marks each line event, and a value bit gives the new level for that bit. The output lines show the level register ANDed with the direction register. They change only after a bus write to the direction or level register. A one-cycle change strobe marks every output bit whose driven value toggled.

The live registers sit at word offsets. The order gives each register's address. Offset 0x00 is mode, 0x04 card detect, 0x08 status (read-only, ready = 0x0002), 0x0C power, 0x10 card control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 GPIO direction, 0x24 GPIO level and 0x28 GPIO readback scratch. The interrupt registers are plain storage. They generate nothing.

Top module: `cmpg_top`

## Requirements
- R1: After reset, the status register reads 0x0002. Every other live register reads 0x0000, and gpio_o and gpio_chg_o are 0.
- R2: A write to mode (0x00), card detect (0x04), card control (0x10), interrupt request (0x14), interrupt mask (0x18), interrupt status (0x1C) or readback (0x28) stores bits 15:0 of wr_data_i. The register then reads back that value.
- R3: A write to power (0x0C) stores bits 15:0 of the data. If data bit 7 is 1, bits 15 and 6 of the stored value are also set.
- R4: Status (0x08) always reads 0x0002. A write to it is ignored.
- R5: Several addresses are not live: any offset with addr bits 1:0 not zero, and any word offset above 0x28 in the window. Such an address reads 0 and a write to it changes no register.
- R6: A write to level (0x24) stores the written value ANDed with the current direction register (0x20).
- R7: gpio_o equals level AND direction. It is updated one clock after a write to direction or level commits, and it holds steady otherwise.
- R8: gpio_chg_o pulses for exactly one cycle, together with the gpio_o update. It is set only in the bits where gpio_o changed, and it is 0 in every other cycle.
- R9: When ext_stb_i[k] is 1 in a cycle, level bit k takes ext_val_i[k] at the next edge, whatever the direction. gpio_o and gpio_chg_o do not react until the next write to direction or level.
- R10: If a bus write to level and an external line event fall in the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset within the register window |
| wr_en_i | input | 1 | Write enable, committed at the rising edge |
| wr_data_i | input | 32 | Write data; only bits 15:0 are used |
| rd_data_o | output | 16 | Combinational read data for addr_i |
| ext_stb_i | input | 16 | Per-line event strobe from external inputs |
| ext_val_i | input | 16 | Level applied to the strobed level bits |
| gpio_o | output | 16 | Driven output lines (level AND direction) |
| gpio_chg_o | output | 16 | One-cycle toggle strobe per output line |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit write bus and 16 GPIO lines. The full-width bus lets tests write data with the upper 16 bits set, which exercises the truncation. The 12-bit window reaches the highest word offset 0xFFC, the first unused offset 0x2C and unaligned addresses. With all 16 lines present, the tests can use direction and level patterns that split the port into groups. Some bits then toggle up, others toggle down and the rest stay unchanged within a single update.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;
  localparam int REG_W    = 16;
  localparam int N_GPIO   = 16;
  localparam int NUM_REGS = 11;

  // word index = byte offset / 4
  localparam int RID_MODE = 0;
  localparam int RID_CDET = 1;
  localparam int RID_STAT = 2;
  localparam int RID_PWR  = 3;
  localparam int RID_CCTL = 4;
  localparam int RID_IREQ = 5;
  localparam int RID_IMSK = 6;
  localparam int RID_ISTS = 7;
  localparam int RID_GDIR = 8;
  localparam int RID_GLVL = 9;
  localparam int RID_GRDB = 10;

  localparam logic [REG_W-1:0] STAT_RST  = 16'h0002;
  localparam int               PWR_TRIG  = 7;
  localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;

  typedef enum logic {REG_PLAIN, REG_POWER} reg_kind_e;

  function automatic bit is_stored(int id);
    return !(id == RID_STAT || id == RID_GDIR || id == RID_GLVL);
  endfunction
endpackage

// File: rtl/cmpg_addr_dec.sv
module cmpg_addr_dec #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 11
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word  = addr_i[ADDR_W-1:2];
  assign hit_o = (addr_i[1:0] == 2'b00) && (int'(word) < NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = hit_o && (int'(word) == i);
  end
endmodule

// File: rtl/cmpg_ctl_reg.sv
module cmpg_ctl_reg
  import cmpg_pkg::*;
#(
  parameter int        W    = 16,
  parameter reg_kind_e KIND = REG_PLAIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  if (KIND == REG_POWER) begin : g_pwr
    always_comb begin
      nxt = wd_i;
      if (wd_i[PWR_TRIG]) nxt = wd_i | W'(PWR_FORCE);
    end
  end else begin : g_plain
    assign nxt = wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= nxt;
  end

  if (KIND == REG_POWER) begin : g_pwr_chk
    AST_PWR_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wd_i[PWR_TRIG]) |=> (q_o[15] && q_o[6] && q_o[PWR_TRIG])); // R3
  end
endmodule

// File: rtl/cmpg_gpio_bank.sv
module cmpg_gpio_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_we_i,
  input  logic         lvl_we_i,
  input  logic [N-1:0] wd_i,
  input  logic [N-1:0] ext_stb_i,
  input  logic [N-1:0] ext_val_i,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] out_o,
  output logic [N-1:0] chg_o
);
  logic         upd_pend;
  logic [N-1:0] drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_o <= '0;
    else if (dir_we_i) dir_o <= wd_i;
  end

  // bus write wins over line events
  for (genvar k = 0; k < N; k++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lvl_o[k] <= 1'b0;
      else if (lvl_we_i)     lvl_o[k] <= wd_i[k] & dir_o[k];
      else if (ext_stb_i[k]) lvl_o[k] <= ext_val_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_pend <= 1'b0;
    else         upd_pend <= dir_we_i | lvl_we_i;
  end

  assign drv = lvl_o & dir_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= '0;
      chg_o <= '0;
    end else if (upd_pend) begin
      out_o <= drv;
      chg_o <= drv ^ out_o;
    end else begin
      chg_o <= '0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd_pend) |-> $stable(out_o)); // R7
  AST_CHG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd_pend) |-> (chg_o == '0)); // R8
  AST_CHG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_pend) |-> (chg_o == (out_o ^ $past(out_o)))); // R8
  AST_LVL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_we_i |=> ((lvl_o & ~$past(dir_o)) == '0)); // R6
endmodule

// File: rtl/cmpg_top.sv
module cmpg_top
  import cmpg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [N_GPIO-1:0] ext_stb_i,
  input  logic [N_GPIO-1:0] ext_val_i,
  output logic [N_GPIO-1:0] gpio_o,
  output logic [N_GPIO-1:0] gpio_chg_o
);
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic [REG_W-1:0]    wd;
  logic [REG_W-1:0]    reg_q [NUM_REGS];
  logic [N_GPIO-1:0]   dir_q, lvl_q;
  logic                unused_wd;

  assign wd        = wr_data_i[REG_W-1:0];
  assign unused_wd = ^wr_data_i[BUS_W-1:REG_W];

  cmpg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (is_stored(i)) begin : g_st
      cmpg_ctl_reg #(
        .W    (REG_W),
        .KIND ((i == RID_PWR) ? REG_POWER : REG_PLAIN)
      ) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_en_i && sel[i]),
        .wd_i   (wd),
        .q_o    (reg_q[i])
      );
    end else if (i == RID_STAT) begin : g_stat
      assign reg_q[i] = STAT_RST;
    end else if (i == RID_GDIR) begin : g_dir
      assign reg_q[i] = REG_W'(dir_q);
    end else begin : g_lvl
      assign reg_q[i] = REG_W'(lvl_q);
    end
  end

  cmpg_gpio_bank #(.N(N_GPIO)) u_gpio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_we_i  (wr_en_i && sel[RID_GDIR]),
    .lvl_we_i  (wr_en_i && sel[RID_GLVL]),
    .wd_i      (wd[N_GPIO-1:0]),
    .ext_stb_i (ext_stb_i),
    .ext_val_i (ext_val_i),
    .dir_o     (dir_q),
    .lvl_o     (lvl_q),
    .out_o     (gpio_o),
    .chg_o     (gpio_chg_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) rd_data_o = rd_data_o | reg_q[i];
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)); // R5
  AST_UNDEF_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rd_data_o == '0)); // R5
  AST_STAT_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel[RID_STAT] |-> (rd_data_o == STAT_RST)); // R4
endmodule

// File: tb/cmpg_top_test.sv
`timescale 1ns/1ps
module cmpg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdat = '0;
  logic [15:0] rdat;
  logic [15:0] stb = '0, val = '0;
  logic [15:0] gout, gchg;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmpg_top uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wdat), .rd_data_o(rdat), .ext_stb_i(stb), .ext_val_i(val),
    .gpio_o(gout), .gpio_chg_o(gchg)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdat = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdat;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 11; i++)
      rd_chk("R1 reset value", 12'(i * 4), (i == 2) ? 16'h0002 : 16'h0000);
    chk("R1 gpio_o reset", gout, 16'h0);
    chk("R1 gpio_chg_o reset", gchg, 16'h0);
  endtask

  task automatic t_plain();
    int offs[7] = '{'h00, 'h04, 'h10, 'h14, 'h18, 'h1C, 'h28};
    for (int i = 0; i < 7; i++)
      wr(12'(offs[i]), 32'hA5A5_0000 | 32'(16'h1111 * (i + 1)));
    for (int i = 0; i < 7; i++)
      rd_chk("R2 plain readback", 12'(offs[i]), 16'(16'h1111 * (i + 1)));
  endtask

  task automatic t_power();
    wr(12'h0C, 32'hFFFF_0123);
    rd_chk("R3 power no trigger", 12'h0C, 16'h0123);
    wr(12'h0C, 32'h0000_0080);
    rd_chk("R3 power trigger", 12'h0C, 16'h80C0);
    wr(12'h0C, 32'h0000_1281);
    rd_chk("R3 power trigger mixed", 12'h0C, 16'h92C1);
    wr(12'h0C, 32'h0000_0040);
    rd_chk("R3 power bit6 only", 12'h0C, 16'h0040);
  endtask

  task automatic t_status();
    wr(12'h08, 32'h0000_FFFF);
    rd_chk("R4 status read-only", 12'h08, 16'h0002);
  endtask

  task automatic t_undef();
    wr(12'h00, 32'h0000_BEEF);
    wr(12'h2C, 32'h0000_1234);
    wr(12'h01, 32'h0000_5678);
    wr(12'h02, 32'h0000_5678);
    wr(12'hFFC, 32'h0000_9ABC);
    wr(12'h0E, 32'h0000_FFFF);
    rd_chk("R5 undefined 0x2C", 12'h2C, 16'h0);
    rd_chk("R5 undefined 0x01", 12'h01, 16'h0);
    rd_chk("R5 undefined 0xFFC", 12'hFFC, 16'h0);
    rd_chk("R5 no side effect mode", 12'h00, 16'hBEEF);
    rd_chk("R5 no side effect power", 12'h0C, 16'h0040);
    rd_chk("R5 no side effect level", 12'h24, 16'h0000);
  endtask

  task automatic t_gpio();
    wr(12'h20, 32'h0000_00FF);
    settle();
    wr(12'h24, 32'h0000_FFFF);
    rd_chk("R6 level masked by dir", 12'h24, 16'h00FF);
    chk("R7 output not yet updated", gout, 16'h0000);
    @(negedge clk);
    chk("R7 output after update", gout, 16'h00FF);
    chk("R8 change strobe", gchg, 16'h00FF);
    @(negedge clk);
    chk("R8 strobe one cycle", gchg, 16'h0000);
    chk("R7 output held", gout, 16'h00FF);
    wr(12'h20, 32'h0000_0F0F);
    rd_chk("R6 level kept on dir write", 12'h24, 16'h00FF);
    @(negedge clk);
    chk("R7 output after dir change", gout, 16'h000F);
    chk("R8 strobe only changed bits", gchg, 16'h00F0);
    @(negedge clk);
    wr(12'h20, 32'h0000_0F0F);
    @(negedge clk);
    chk("R8 no strobe without change", gchg, 16'h0000);
    chk("R7 output unchanged", gout, 16'h000F);
  endtask

  task automatic t_ext();
    wr(12'h20, 32'h0000_FFFF);
    wr(12'h24, 32'h0000_000F);
    settle();
    chk("R7 output setup", gout, 16'h000F);
    @(negedge clk);
    stb = 16'hF001; val = 16'hF000;
    @(negedge clk);
    stb = '0; val = '0;
    rd_chk("R9 level set by lines", 12'h24, 16'hF00E);
    chk("R9 no strobe from lines", gchg, 16'h0000);
    @(negedge clk);
    chk("R9 output unchanged", gout, 16'h000F);
    chk("R9 still no strobe", gchg, 16'h0000);
    wr(12'h20, 32'h0000_FFFF);
    @(negedge clk);
    chk("R9 output after dir write", gout, 16'hF00E);
    chk("R9 strobe after dir write", gchg, 16'hF001);
    wr(12'h20, 32'h0000_0000);
    settle();
    @(negedge clk);
    stb = 16'h0100; val = 16'h0100;
    @(negedge clk);
    stb = '0; val = '0;
    rd_chk("R9 line ignores direction", 12'h24, 16'hF10E);
  endtask

  task automatic t_collide();
    wr(12'h20, 32'h0000_FFFF);
    settle();
    @(negedge clk);
    addr = 12'h24; wdat = 32'h0000_0000; we = 1'b1;
    stb = 16'h0002; val = 16'h0002;
    @(negedge clk);
    we = 1'b0; stb = '0; val = '0;
    rd_chk("R10 bus write wins", 12'h24, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_power();
    t_status();
    t_undef();
    t_gpio();
    t_ext();
    t_collide();
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule